// File: doc/BRIEF.md
# Ping-Pong Video Capture Controller

This block writes a stream of 8-bit digitized video samples into an external dual-port memory that is treated as two equal halves. It produces the sample clock for the analog-to-digital converter, latches one pixel on each rising edge of that clock, and drives the memory's write port: address, data, chip select and write enable. The write address is a single counter. Its top bit selects the half being filled, so writing runs from the end of one half straight into the start of the other with no gap.

Each time the last location of a half is written, the block sends a one-cycle interrupt pulse to both processors and records which half has just completed. The processors then read that half while new samples go into the other one. The separated field sync is the time base. Capture becomes active only at a field sync that arrives while capture is enabled, and every field sync returns the address counter to the start of the first half. A line sync realigns the sample clock phase and leaves the address unchanged.

Top module: `vcap_pingpong`

## Requirements
- R1: After reset the block is in this state: `mem_cs_n` and `mem_we_n` high, `mem_addr` 0, `mem_data` 0, `irq` low, `wr_half` 0, `done_half` 0, `adc_clk` high.
- R2: The sample clock has a period of N system cycles, where N is `div_ratio`, or 2 when `div_ratio` is below 2. It is high for the first floor(N/2) cycles of each period. The cycle in which it goes high is the sampling cycle.
- R3: Capture is armed by a clock edge at which `fsync` and `cap_en` are both high. It is disarmed by any edge at which `cap_en` is low. A sample is written only if the block is armed at the edge where that sample is taken, so re-enabling without a field sync writes nothing.
- R4: Each write is a single cycle in which `mem_cs_n` and `mem_we_n` are low together. It appears one cycle after the sampling edge, and `mem_data` carries `pix_in` as it stood at that edge.
- R5: Successive writes use successive addresses of width log2(HALF_DEPTH)+1. The address wraps from 2*HALF_DEPTH-1 to 0, and bit log2(HALF_DEPTH) is the half-select.
- R6: A clock edge with `fsync` high resets the address counter to 0, which selects half 0. That edge writes nothing and raises no interrupt.
- R7: `irq` is a one-cycle pulse. It is raised together with the write strobe for the last location of a half, which is the location whose low address bits are all ones.
- R8: `done_half` takes the half-select bit of the write that completed a half, in the same cycle as `irq`. `wr_half` shows the half that the next write goes to.
- R9: A clock edge with `lsync` or `fsync` high restarts the sample clock period, so the clock is high and a sampling cycle follows on the next cycle. A line sync leaves the address counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable |
| fsync | input | 1 | Separated field sync pulse |
| lsync | input | 1 | Separated line sync pulse |
| div_ratio | input | DIV_W | Sample clock division ratio |
| pix_in | input | PIX_W | Digitized pixel from the converter |
| adc_clk | output | 1 | Sample clock to the converter |
| mem_addr | output | log2(HALF_DEPTH)+1 | Memory write address, top bit selects the half |
| mem_data | output | PIX_W | Memory write data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| wr_half | output | 1 | Half currently being filled |
| done_half | output | 1 | Half most recently completed |
| irq | output | 1 | Half-full interrupt pulse to both processors |

## Verification
The stimulus runs the pixel stream at the fastest division ratio for more than two full halves. That run separates a correct address wrap and interrupt placement from an off-by-one at the half boundary. The ratio is then changed to an odd value and to a value below the minimum, which shows whether the clamp and the high-phase length are right. Line syncs and a field sync are injected in the middle of a half; these show that realignment of the sample clock is kept apart from the address reset. Finally, enable is removed and restored with and without a field sync, which tells a correct arming rule from one that resumes too early.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  localparam int unsigned MIN_RATIO = 2;

  typedef struct packed {
    logic cs_n;
    logic we_n;
  } mem_strobe_t;

  localparam mem_strobe_t STROBE_IDLE  = '{cs_n: 1'b1, we_n: 1'b1};
  localparam mem_strobe_t STROBE_WRITE = '{cs_n: 1'b0, we_n: 1'b0};

  // Division ratio actually used by the sample clock generator.
  function automatic int unsigned clamp_ratio(input int unsigned r);
    return (r < MIN_RATIO) ? MIN_RATIO : r;
  endfunction

endpackage

// File: rtl/vcap_clkgen.sv
module vcap_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             adc_clk,
  output logic             tick
);
  logic [DIV_W-1:0] eff;
  logic [DIV_W-1:0] phase_q;

  assign eff = DIV_W'(vcap_pkg::clamp_ratio(32'(div_ratio)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase_q <= '0;
    else if (resync)            phase_q <= '0;
    else if (phase_q >= eff - 1'b1) phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  assign adc_clk = (phase_q < (eff >> 1));
  assign tick    = (phase_q == '0) && !resync;
endmodule

// File: rtl/vcap_arm.sv
module vcap_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic fsync,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (!cap_en) armed <= 1'b0;
    else if (fsync)  armed <= 1'b1;
  end
endmodule

// File: rtl/vcap_wrctl.sv
module vcap_wrctl #(
  parameter int PIX_W  = 8,
  parameter int HALF_W = 14,
  localparam int ADDR_W = HALF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              wr_go,
  input  logic [PIX_W-1:0]  pix_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_data,
  output vcap_pkg::mem_strobe_t strobe,
  output logic              wr_half,
  output logic              done_half,
  output logic              irq
);
  logic [ADDR_W-1:0] ptr_q;
  logic              last_slot;

  assign last_slot = &ptr_q[HALF_W-1:0];
  assign wr_half   = ptr_q[ADDR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      mem_addr  <= '0;
      mem_data  <= '0;
      strobe    <= vcap_pkg::STROBE_IDLE;
      irq       <= 1'b0;
      done_half <= 1'b0;
    end else begin
      strobe <= vcap_pkg::STROBE_IDLE;
      irq    <= 1'b0;
      if (fsync) begin
        ptr_q <= '0;
      end else if (wr_go) begin
        mem_addr <= ptr_q;
        mem_data <= pix_in;
        strobe   <= vcap_pkg::STROBE_WRITE;
        ptr_q    <= ptr_q + 1'b1;
        if (last_slot) begin
          irq       <= 1'b1;
          done_half <= ptr_q[ADDR_W-1];
        end
      end
    end
  end
endmodule

// File: rtl/vcap_pingpong.sv
module vcap_pingpong #(
  parameter int PIX_W      = 8,
  parameter int HALF_DEPTH = 16384,
  parameter int DIV_W      = 8,
  localparam int HALF_W    = $clog2(HALF_DEPTH),
  localparam int ADDR_W    = HALF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              fsync,
  input  logic              lsync,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic [PIX_W-1:0]  pix_in,
  output logic              adc_clk,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_data,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              wr_half,
  output logic              done_half,
  output logic              irq
);
  // Internal events, named for the checker.
  logic samp_tick;
  logic armed_w;
  logic wr_go;
  logic resync;
  vcap_pkg::mem_strobe_t strobe;

  assign resync = fsync | lsync;
  assign wr_go  = armed_w & samp_tick;

  vcap_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .resync(resync), .div_ratio(div_ratio),
    .adc_clk(adc_clk), .tick(samp_tick)
  );

  vcap_arm u_arm (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .fsync(fsync), .armed(armed_w)
  );

  vcap_wrctl #(.PIX_W(PIX_W), .HALF_W(HALF_W)) u_wrctl (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .wr_go(wr_go), .pix_in(pix_in),
    .mem_addr(mem_addr), .mem_data(mem_data), .strobe(strobe),
    .wr_half(wr_half), .done_half(done_half), .irq(irq)
  );

  assign mem_cs_n = strobe.cs_n;
  assign mem_we_n = strobe.we_n;
endmodule

// File: rtl/vcap_pp_checker.sv
module vcap_pp_checker #(
  parameter int HALF_W = 14,
  localparam int ADDR_W = HALF_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fsync,
  input logic              armed,
  input logic              tick,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              wr_half,
  input logic              done_half,
  input logic              irq
);
  a_r4_strobes_paired: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n == mem_we_n);

  a_r3_write_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $past(armed && tick));

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r7_irq_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!mem_we_n && (&mem_addr[HALF_W-1:0])));

  a_r8_done_matches: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_half == mem_addr[ADDR_W-1]));

  a_r6_fsync_half0: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (!wr_half && !irq && mem_we_n));

  a_r8_half_flips_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (wr_half != done_half));
endmodule

bind vcap_pingpong vcap_pp_checker #(.HALF_W(HALF_W)) u_pp_checker (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .armed(armed_w), .tick(samp_tick),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .wr_half(wr_half), .done_half(done_half), .irq(irq)
);

// File: tb/test_vcap_pingpong.sv
module test_vcap_pingpong;
  localparam int HALF  = 16;
  localparam int AW    = 5;
  localparam int DW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_en = 1'b0, fsync = 1'b0, lsync = 1'b0;
  logic [DW-1:0] div_ratio = 4'd2;
  logic [7:0] pix_in = 8'd5;
  logic adc_clk, mem_cs_n, mem_we_n, wr_half, done_half, irq;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;

  always #4 clk = ~clk;

  vcap_pingpong #(.PIX_W(8), .HALF_DEPTH(HALF), .DIV_W(DW)) i_vcap_pingpong (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .fsync(fsync), .lsync(lsync),
    .div_ratio(div_ratio), .pix_in(pix_in), .adc_clk(adc_clk),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .wr_half(wr_half), .done_half(done_half), .irq(irq)
  );

  int vectors = 0, fails = 0;
  int wr_cnt = 0, irq_cnt = 0;
  bit finished = 1'b0;

  // Behavioural reference model state.
  int m_phase = 0, m_ptr = 0, m_addr = 0, m_data = 0, m_done = 0;
  bit m_armed = 0, m_wr = 0, m_irq = 0;

  function automatic int ratio_of(input int r);
    return (r < 2) ? 2 : r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_ptr = 0; m_addr = 0; m_data = 0; m_done = 0;
      m_armed = 0; m_wr = 0; m_irq = 0;
    end else begin
      bit sync_now;
      bit sample;
      sync_now = fsync || lsync;
      sample   = (m_phase == 0) && !sync_now;
      m_wr = 0; m_irq = 0;
      if (fsync) m_ptr = 0;
      else if (m_armed && sample) begin
        m_wr = 1; m_addr = m_ptr; m_data = pix_in;
        if ((m_ptr % HALF) == HALF - 1) begin m_irq = 1; m_done = m_ptr / HALF; end
        m_ptr = (m_ptr + 1) % (2 * HALF);
      end
      if (!cap_en) m_armed = 0;
      else if (fsync) m_armed = 1;
      if (sync_now) m_phase = 0;
      else if (m_phase >= ratio_of(div_ratio) - 1) m_phase = 0;
      else m_phase = m_phase + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2/R9 adc_clk", adc_clk, m_phase < ratio_of(div_ratio) / 2);
      chk("R4 mem_we_n", mem_we_n, !m_wr);
      chk("R4 mem_cs_n", mem_cs_n, !m_wr);
      chk("R5 mem_addr", mem_addr, m_addr);
      chk("R4 mem_data", mem_data, m_data);
      chk("R7 irq", irq, m_irq);
      chk("R8 wr_half", wr_half, m_ptr / HALF);
      chk("R8 done_half", done_half, m_done);
      if (!mem_we_n) wr_cnt++;
      if (irq) irq_cnt++;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      pix_in = pix_in + 8'd37;
    end
  endtask

  task automatic pulse_f();
    fsync = 1'b1; step(1); fsync = 1'b0;
  endtask

  task automatic pulse_l();
    lsync = 1'b1; step(1); lsync = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 mem_we_n", mem_we_n, 1);
    chk("R1 mem_cs_n", mem_cs_n, 1);
    chk("R1 irq", irq, 0);
    chk("R1 mem_addr", mem_addr, 0);
    chk("R1 wr_half", wr_half, 0);
    chk("R1 adc_clk", adc_clk, 1);
    step(1);

    // R3: enabled but no field sync yet, so nothing is written
    cap_en = 1'b1; wr_cnt = 0;
    step(20);
    chk("R3 no write before field sync", wr_cnt, 0);

    // R5 R7: ratio 2, more than two halves, wrap across the boundary
    pulse_f(); irq_cnt = 0; wr_cnt = 0;
    step(70);
    chk("R7 two interrupts over two halves", irq_cnt, 2);
    chk("R5 writes at ratio 2", wr_cnt, 35);

    // R9: line syncs realign the sample clock only
    pulse_l(); step(5); pulse_l(); step(9);

    // R2: odd ratio and a ratio below the minimum
    div_ratio = 4'd5; step(60);
    div_ratio = 4'd0; step(30);
    div_ratio = 4'd3; step(40);

    // R6: field sync in the middle of a half
    div_ratio = 4'd2; step(7);
    pulse_f();
    @(negedge clk);
    chk("R6 half 0 after field sync", wr_half, 0);
    step(40);

    // R3: disable, re-enable without field sync, then rearm
    cap_en = 1'b0; step(2); wr_cnt = 0;
    step(30);
    chk("R3 no write while disabled", wr_cnt, 0);
    cap_en = 1'b1; step(20);
    chk("R3 no write until field sync", wr_cnt, 0);
    pulse_f(); step(20);
    chk("R3 writes resume after field sync", wr_cnt, 10);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule